// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit holds the program counter of a small 32-bit load/store core and decides, every cycle, where it goes next. The core has no branch delay slot: when a branch or jump resolves as taken, the PC moves to the target at the next clock edge, and the instruction after the branch never runs. Six signed compare conditions between two register operands are supported. Branch targets are PC-relative with a word-scaled 16-bit offset. Jumps take a 26-bit pseudo-direct target.

The decode stage presents one instruction per cycle on `issue`, together with its operand values, offset, jump target and control bits. The unit returns the next PC, a taken flag, and a request to write the return address into register 31 for jump-and-link. It also raises `halt` once the PC points at or beyond the end of the loaded program. The end is given by the instruction count on `insn_count`, with code starting at 0x00400000. While halted, the PC stays frozen.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst_n` is low, and at the first cycle after it rises, `pc` equals 0x00400000.
- R2: `br_type` selects the condition, with `rs_val` and `rt_val` compared as signed 32-bit values: 0 = none, 1 = equal, 2 = not equal, 3 = rs<rt, 4 = rs>rt, 5 = rs<=rt, 6 = rs>=rt, 7 = never taken.
- R3: A taken branch gives `next_pc` = (pc+4) + (sign-extended `br_off` × 4). A branch whose condition is false gives pc+4.
- R4: When `is_jump` is high, `next_pc` = {bits 31:28 of pc+4, `jmp_tgt`, 2'b00}, whatever `br_type` holds.
- R5: A jump with `is_link` high raises `link_we`, with `link_dst` = 31 and `link_addr` = pc+4. `link_we` stays low in every other case.
- R6: There is no delay slot. After an active cycle, `pc` at the next edge equals `next_pc`, and `taken` is high exactly when a jump or a true branch condition redirects the PC.
- R7: With `issue` low, `pc` holds, and `taken` and `link_we` are low.
- R8: `halt` is high when (pc − 0x00400000)/4 ≥ `insn_count`, with `insn_count` values above MAX_INSNS (256) treated as 256. A count of 0 halts right out of reset.
- R9: While `halt` is high, `pc` holds, `next_pc` equals `pc`, and `taken` and `link_we` stay low.
- R10: `pc` and `next_pc` are always word aligned (bits 1:0 are zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue | input | 1 | A decoded instruction is present this cycle |
| br_type | input | 3 | Branch condition code (see R2) |
| is_jump | input | 1 | Instruction is a pseudo-direct jump |
| is_link | input | 1 | Jump also writes the return address |
| rs_val | input | 32 | First compare operand |
| rt_val | input | 32 | Second compare operand |
| br_off | input | 16 | Signed word offset for branches |
| jmp_tgt | input | 26 | Jump target word index |
| insn_count | input | 10 | Number of loaded instructions |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | PC value at the next edge |
| taken | output | 1 | Control transfer taken this cycle |
| link_we | output | 1 | Write return address to link register |
| link_dst | output | 5 | Link register index (31) |
| link_addr | output | 32 | Return address |
| halt | output | 1 | PC is past the loaded program |

## Verification
The assertions check on every cycle the parts of the behaviour that do not depend on data values. These are: the PC follows `next_pc` at each edge, and it holds when idle or halted. `taken` and `link_we` stay quiet under halt or idle. Word alignment holds, and the link index is fixed. Whether each of the six signed conditions resolves correctly, including the sign boundary, and whether the branch and jump targets are computed correctly, can only be shown by the bench's scenarios against its own model. The same holds for halt placement at the program end and for the clamp of an oversized count.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter int          XLEN      = 32,
  parameter int          OFF_W     = 16,
  parameter int          TGT_W     = 26,
  parameter int          CNT_W     = 10,
  parameter int          MAX_INSNS = 256,
  parameter logic [31:0] CODE_BASE = 32'h0040_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [2:0]       br_type,
  input  logic             is_jump,
  input  logic             is_link,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [OFF_W-1:0] br_off,
  input  logic [TGT_W-1:0] jmp_tgt,
  input  logic [CNT_W-1:0] insn_count,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  next_pc,
  output logic             taken,
  output logic             link_we,
  output logic [4:0]       link_dst,
  output logic [XLEN-1:0]  link_addr,
  output logic             halt
);
  localparam int HI_W  = XLEN - TGT_W - 2;
  localparam int IDX_W = XLEN - 2;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_INSNS);

  logic [XLEN-1:0]  seq_pc, br_pc, jmp_pc, rel;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] eff_cnt;
  logic             lt, eq, cond, active;

  assign seq_pc = pc + XLEN'(4);
  assign br_pc  = seq_pc + {{(XLEN-OFF_W-2){br_off[OFF_W-1]}}, br_off, 2'b00};
  assign jmp_pc = {seq_pc[XLEN-1 -: HI_W], jmp_tgt, 2'b00};

  assign eq = (rs_val == rt_val);
  assign lt = ($signed(rs_val) < $signed(rt_val));

  always_comb begin
    unique case (br_type)
      3'd1:    cond = eq;
      3'd2:    cond = !eq;
      3'd3:    cond = lt;
      3'd4:    cond = !lt && !eq;
      3'd5:    cond = lt || eq;
      3'd6:    cond = !lt;
      default: cond = 1'b0;
    endcase
  end

  assign rel     = pc - CODE_BASE;
  assign idx     = rel[XLEN-1:2];
  assign eff_cnt = (insn_count > CNT_MAX) ? CNT_MAX : insn_count;
  assign halt    = (idx >= IDX_W'(eff_cnt));

  assign active    = issue && !halt;
  assign taken     = active && (is_jump || cond);
  assign link_we   = active && is_jump && is_link;
  assign link_dst  = 5'd31;
  assign link_addr = seq_pc;

  always_comb begin
    if (!active)      next_pc = pc;
    else if (is_jump) next_pc = jmp_pc;
    else if (cond)    next_pc = br_pc;
    else              next_pc = seq_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= CODE_BASE;
    else        pc <= next_pc;
  end
endmodule

// File: rtl/next_pc_unit_chk.sv
module next_pc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issue,
  input logic [2:0]  br_type,
  input logic        is_jump,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic        taken,
  input logic        link_we,
  input logic [4:0]  link_dst,
  input logic        halt
);
  a_r6_pc_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pc == $past(next_pc));
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(pc));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> !taken && !link_we);
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(pc));
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !taken && !link_we);
  a_r6_taken_cause: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> is_jump || br_type != 3'd0);
  a_r5_link_jump: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> taken && link_dst == 5'd31);
  a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00 && next_pc[1:0] == 2'b00);
  a_r1_reset_pc: assert property (@(posedge clk)
    !rst_n |=> pc == 32'h0040_0000);
endmodule

bind next_pc_unit next_pc_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .br_type(br_type),
  .is_jump(is_jump), .pc(pc), .next_pc(next_pc), .taken(taken),
  .link_we(link_we), .link_dst(link_dst), .halt(halt)
);

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;
  localparam logic [31:0] BASE = 32'h0040_0000;

  logic        clk = 1'b0, rst_n = 1'b0, issue = 1'b0, is_jump = 1'b0, is_link = 1'b0;
  logic [2:0]  br_type = 3'd0;
  logic [31:0] rs_val = '0, rt_val = '0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_tgt = '0;
  logic [9:0]  insn_count = 10'd256;
  logic [31:0] pc, next_pc, link_addr;
  logic        taken, link_we, halt;
  logic [4:0]  link_dst;

  int total = 0, bad = 0;
  logic [31:0] mpc;

  always #5 clk = ~clk;

  next_pc_unit i_next_pc_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .br_type(br_type),
    .is_jump(is_jump), .is_link(is_link), .rs_val(rs_val), .rt_val(rt_val),
    .br_off(br_off), .jmp_tgt(jmp_tgt), .insn_count(insn_count),
    .pc(pc), .next_pc(next_pc), .taken(taken), .link_we(link_we),
    .link_dst(link_dst), .link_addr(link_addr), .halt(halt)
  );

  function automatic logic m_cond(input logic [2:0] t, input logic [31:0] a, input logic [31:0] b);
    case (t)
      3'd1: return $signed(a) == $signed(b);
      3'd2: return $signed(a) != $signed(b);
      3'd3: return $signed(a) <  $signed(b);
      3'd4: return $signed(a) >  $signed(b);
      3'd5: return $signed(a) <= $signed(b);
      3'd6: return $signed(a) >= $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic m_halt(input logic [31:0] p, input logic [9:0] c);
    int unsigned lim;
    lim = (c > 10'd256) ? 256 : int'(c);
    return ((p - BASE) >> 2) >= lim;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; issue = 1'b0;
    @(posedge clk); #1;
    check("R1 reset pc", pc, BASE);
    @(negedge clk); rst_n = 1'b1; mpc = BASE;
    #1 check("R1 pc after reset", pc, BASE);
  endtask

  task automatic step(input logic iss, input logic [2:0] t, input logic j, input logic l,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] off, input logic [25:0] tg);
    logic h, c, tk, lw;
    logic [31:0] seq, exp;
    @(negedge clk);
    issue = iss; br_type = t; is_jump = j; is_link = l;
    rs_val = a; rt_val = b; br_off = off; jmp_tgt = tg;
    #1;
    h   = m_halt(mpc, insn_count);
    seq = mpc + 32'd4;
    c   = m_cond(t, a, b);
    tk  = iss && !h && (j || c);
    lw  = iss && !h && j && l;
    if (!iss || h)  exp = mpc;
    else if (j)     exp = {seq[31:28], tg, 2'b00};
    else if (c)     exp = seq + {{14{off[15]}}, off, 2'b00};
    else            exp = seq;
    check("R8 halt", {31'd0, halt}, {31'd0, h});
    check("R2 R3 R4 next_pc", next_pc, exp);
    check("R6 R7 R9 taken", {31'd0, taken}, {31'd0, tk});
    check("R5 link_we", {31'd0, link_we}, {31'd0, lw});
    if (lw) begin
      check("R5 link_addr", link_addr, seq);
      check("R5 link_dst", {27'd0, link_dst}, 32'd31);
    end
    @(posedge clk); #1;
    mpc = exp;
    check("R6 no delay slot pc", pc, mpc);
    check("R10 aligned", {30'd0, pc[1:0]}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    insn_count = 10'd256;
    do_reset();
    // R2 directed: sign boundary and equality for each code
    for (int t = 0; t < 8; t++) begin
      step(1, 3'(t), 0, 0, 32'hFFFF_FFFF, 32'd1, 16'd3, '0);
      step(1, 3'(t), 0, 0, 32'd5, 32'd5, 16'hFFFF, '0);
      step(1, 3'(t), 0, 0, 32'h7FFF_FFFF, 32'h8000_0000, 16'd1, '0);
    end
    // R4 jump wins over branch type, R5 link
    step(1, 3'd1, 1, 1, 32'd1, 32'd1, 16'd9, 26'h010_0020);
    step(1, 3'd0, 1, 0, 0, 0, 0, 26'h010_0004);
    // R7 idle cycles
    step(0, 3'd1, 1, 1, 0, 0, 16'd4, 26'h010_0050);
    step(0, 3'd3, 0, 0, 32'd1, 32'd2, 16'd4, 0);
    // random phase, targets kept inside the program
    for (int n = 0; n < 3000; n++) begin
      int unsigned cur, dst;
      logic [2:0] t;
      logic j;
      cur = (mpc - BASE) >> 2;
      dst = $urandom_range(0, 255);
      t = 3'($urandom_range(0, 7));
      j = ($urandom_range(0, 5) == 0);
      step(($urandom_range(0, 9) != 0), t, j, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 1) != 0) ? $urandom() : 32'($urandom_range(0, 3)) - 32'd1,
           ($urandom_range(0, 1) != 0) ? $urandom() : 32'($urandom_range(0, 3)) - 32'd1,
           16'(int'(dst) - int'(cur) - 1), 26'h010_0000 + 26'(dst));
      if (m_halt(mpc, insn_count)) do_reset();
    end
    // R8 run off a three-instruction program, R9 frozen after
    insn_count = 10'd3;
    do_reset();
    for (int n = 0; n < 3; n++) step(1, 3'd0, 0, 0, 0, 0, 0, 0);
    check("R8 halt at end", {31'd0, halt}, 32'd1);
    step(1, 3'd1, 1, 1, 0, 0, 16'd2, 26'h010_0000);
    check("R9 pc frozen", pc, BASE + 32'd12);
    // R8 zero count halts at once
    insn_count = 10'd0;
    do_reset();
    #1 check("R8 zero count", {31'd0, halt}, 32'd1);
    step(1, 3'd0, 1, 0, 0, 0, 0, 26'h010_0003);
    // R8 count above limit is clamped
    insn_count = 10'd300;
    do_reset();
    step(1, 3'd0, 1, 0, 0, 0, 0, 26'h010_00FF);
    check("R8 last slot runs", {31'd0, halt}, 32'd0);
    step(1, 3'd0, 0, 0, 0, 0, 0, 0);
    check("R8 clamp to 256", {31'd0, halt}, 32'd1);
    step(1, 3'd0, 0, 0, 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule